// File: doc/BRIEF.md
# Real-Time-Clock Register Bank with Read Snapshot and Staged Writes

This block holds the sixteen byte-wide registers of a real-time clock behind a simple byte access port. One register holds the two control flags. Seven hold the running date and time in BCD and advance on a 1 Hz tick. The remaining eight are general control bytes. A host opens an access by pulsing `start` with a register address. Each read or write strobe then touches the current register and steps the address, so one strobe gives a single access and a run of strobes gives a burst.

Two flags keep software and the running clock from disturbing each other. Setting the read-hold flag freezes a copy of the time, and timekeeping reads return that copy until the flag is cleared. A carry between two bytes of a burst read therefore cannot tear the result. Setting the write-hold flag copies the live time into a staging bank and unlocks writes to every register except the flags. Timekeeping writes land in the staging bank while the live counters keep running. Clearing the flag loads the whole staged time into the counters in one cycle.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the flags and the eight control bytes read 0x00, seconds, minutes, hours and year read 0x00, and day of week, date and month read 0x01.
- R2: A strobe in the same cycle as `start` accesses `start_addr`. Read data appears on `rd_data` one clock after `rd_stb` and holds until the next read strobe.
- R3: Every strobe steps the access address by one, wrapping from 15 to 0, so a burst may start at any register.
- R4: The timekeeping registers sit at addresses 1 to 7 (seconds, minutes, hours, day of week 1..7, date 1..31, month 1..12, year 00..99). They count in BCD on each `tick_1hz`, with seconds carrying into minutes and then hours. A wrap of hours advances both day of week and date. Every month is treated as 31 days long.
- R5: Setting the read-hold flag (flags bit 0) from 0 to 1 captures the live time. While the flag stays at 1, reads of addresses 1 to 7 return the captured values even as the counters advance. Once it is cleared, reads return live values.
- R6: While the write-hold flag (flags bit 1) is 0, writes to addresses 1 to 15 are discarded. The flags register at address 0 accepts writes at any time.
- R7: When the write-hold flag rises, the staging bank loads the live time. Writes to addresses 1 to 7 then update only the staging bank, and the live counters keep ticking. When the flag falls, the counters load the staging bank, and any tick in that cycle is ignored.
- R8: The flags register keeps only bits 1 and 0. Bits 7 to 2 always read 0.
- R9: While the write-hold flag is 1, the control bytes at addresses 8 to 15 store written data and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| start | input | 1 | Opens an access at `start_addr` |
| start_addr | input | 4 | First register of the access |
| wr_stb | input | 1 | Write the current register |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read the current register |
| rd_data | output | 8 | Registered read data |

## Verification
Four properties are checked on every cycle. The access address steps and wraps on each strobe. The snapshot stays still while read-hold is held. The control bytes stay unchanged while write-hold is low. The staging bank and the live counters exchange their contents on the rising and falling edges of write-hold. Other behaviour can only be shown by the bench's scenarios: the BCD carry chain across digit and field boundaries, the full-date rollover, the returned read data, and the reserved flag bits. These need chosen start times and an end-to-end view through the access port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RTC_REGS    = 16;
    localparam int ADDR_W      = $clog2(RTC_REGS);
    localparam int DATA_W      = 8;
    localparam int TIME_FIELDS = 7;
    localparam int FIELD_W     = $clog2(TIME_FIELDS);
    localparam int FLAGS_ADDR  = 0;
    localparam int TIME_BASE   = 1;
    localparam int CTRL_BASE   = TIME_BASE + TIME_FIELDS;
    localparam int CTRL_REGS   = RTC_REGS - CTRL_BASE;
    localparam int CTRL_W      = $clog2(CTRL_REGS);

    typedef logic [DATA_W-1:0] byte_t;
    typedef byte_t [TIME_FIELDS-1:0] time_vec_t;

    typedef struct packed {
        logic [DATA_W-3:0] rsvd;
        logic              wr_hold;
        logic              rd_hold;
    } flags_t;

    // field order: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year
    function automatic byte_t field_lo(input int i);
        return (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
    endfunction

    function automatic byte_t field_hi(input int i);
        case (i)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            3:       return 8'h07;
            4:       return 8'h31;
            5:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    // field whose wrap advances field i; -1 means the 1 Hz tick
    function automatic int field_parent(input int i);
        case (i)
            0:       return -1;
            3, 4:    return 2;
            default: return i - 1;
        endcase
    endfunction

    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic time_vec_t time_reset();
        time_vec_t t;
        for (int i = 0; i < TIME_FIELDS; i++) t[i] = field_lo(i);
        return t;
    endfunction
endpackage

// File: rtl/rtc_bcd_counters.sv
module rtc_bcd_counters
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  time_vec_t load_val,
    output time_vec_t live
);
    logic [TIME_FIELDS-1:0] at_max;
    logic [TIME_FIELDS-1:0] step;

    always_comb begin
        for (int i = 0; i < TIME_FIELDS; i++) at_max[i] = (live[i] == field_hi(i));
    end

    // a field steps when the tick arrives and every ancestor sits at its maximum
    always_comb begin
        for (int i = 0; i < TIME_FIELDS; i++) begin
            logic e;
            int   j;
            e = tick;
            j = field_parent(i);
            for (int k = 0; k < TIME_FIELDS; k++) begin
                if (j >= 0) begin
                    e = e & at_max[j[FIELD_W-1:0]];
                    j = field_parent(j);
                end
            end
            step[i] = e;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= time_reset();
        end else if (load) begin
            live <= load_val;
        end else begin
            for (int i = 0; i < TIME_FIELDS; i++) begin
                if (step[i]) live[i] <= at_max[i] ? field_lo(i) : bcd_inc(live[i]);
            end
        end
    end
endmodule

// File: rtl/rtc_time_shadow.sv
module rtc_time_shadow
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  time_vec_t          live,
    input  logic               snap_take,
    input  logic               stage_take,
    input  logic               stage_we,
    input  logic [FIELD_W-1:0] stage_idx,
    input  byte_t              stage_wdata,
    output time_vec_t          snap,
    output time_vec_t          stage
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= time_reset();
            stage <= time_reset();
        end else begin
            if (snap_take) snap <= live;
            if (stage_take)    stage <= live;
            else if (stage_we) stage[stage_idx] <= stage_wdata;
        end
    end
endmodule

// File: rtl/rtc_burst_ptr.sv
module rtc_burst_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] ptr_q
);
    assign cur_addr = start ? start_addr : ptr_q;

    always_ff @(posedge clk) begin
        if (rst)        ptr_q <= '0;
        else if (step)  ptr_q <= cur_addr + AW'(1);
        else if (start) ptr_q <= start_addr;
    end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] acc_addr, ptr_q;
    flags_t            flags_q;
    byte_t [CTRL_REGS-1:0] ctrl_q;
    logic [CTRL_REGS-1:0]  ctrl_we;
    time_vec_t         live, snap, stage;
    logic              is_flags, is_time, is_ctrl;
    logic              flags_wr, r_rise, w_rise, w_fall, stage_we;
    logic [FIELD_W-1:0] time_idx;
    logic [CTRL_W-1:0]  ctrl_idx;
    byte_t             rd_mux;

    rtc_burst_ptr #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .step(wr_stb | rd_stb), .cur_addr(acc_addr), .ptr_q(ptr_q)
    );

    assign is_flags = (acc_addr == ADDR_W'(FLAGS_ADDR));
    assign is_time  = (acc_addr >= ADDR_W'(TIME_BASE)) && (acc_addr < ADDR_W'(CTRL_BASE));
    assign is_ctrl  = (acc_addr >= ADDR_W'(CTRL_BASE));
    assign time_idx = FIELD_W'(acc_addr - ADDR_W'(TIME_BASE));
    assign ctrl_idx = CTRL_W'(acc_addr - ADDR_W'(CTRL_BASE));

    assign flags_wr = wr_stb & is_flags;
    assign r_rise   = flags_wr &  wr_data[0] & ~flags_q.rd_hold;
    assign w_rise   = flags_wr &  wr_data[1] & ~flags_q.wr_hold;
    assign w_fall   = flags_wr & ~wr_data[1] &  flags_q.wr_hold;
    assign stage_we = wr_stb & is_time & flags_q.wr_hold;

    always_ff @(posedge clk) begin
        if (rst)           flags_q <= '0;
        else if (flags_wr) flags_q <= '{rsvd: '0, wr_hold: wr_data[1], rd_hold: wr_data[0]};
    end

    rtc_bcd_counters u_cnt (
        .clk(clk), .rst(rst), .tick(tick_1hz), .load(w_fall),
        .load_val(stage), .live(live)
    );

    rtc_time_shadow u_shadow (
        .clk(clk), .rst(rst), .live(live), .snap_take(r_rise),
        .stage_take(w_rise), .stage_we(stage_we), .stage_idx(time_idx),
        .stage_wdata(wr_data), .snap(snap), .stage(stage)
    );

    for (genvar g = 0; g < CTRL_REGS; g++) begin : g_ctrl
        assign ctrl_we[g] = wr_stb & is_ctrl & flags_q.wr_hold & (ctrl_idx == CTRL_W'(g));
        always_ff @(posedge clk) begin
            if (rst)             ctrl_q[g] <= '0;
            else if (ctrl_we[g]) ctrl_q[g] <= wr_data;
        end
    end

    always_comb begin
        if (is_flags)     rd_mux = flags_q;
        else if (is_time) rd_mux = flags_q.rd_hold ? snap[time_idx] : live[time_idx];
        else              rd_mux = ctrl_q[ctrl_idx];
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_stb) rd_data <= rd_mux;
    end
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
    import rtc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  wr_stb,
    input logic                  rd_stb,
    input logic [ADDR_W-1:0]     ptr_q,
    input flags_t                flags_q,
    input byte_t [CTRL_REGS-1:0] ctrl_q,
    input time_vec_t             live,
    input time_vec_t             snap,
    input time_vec_t             stage
);
    p_burst_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb || rd_stb) && !start |=> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)));

    p_snap_hold_r5: assert property (@(posedge clk) disable iff (rst)
        flags_q.rd_hold && $past(flags_q.rd_hold) |-> $stable(snap));

    p_ctrl_locked_r6: assert property (@(posedge clk) disable iff (rst)
        !flags_q.wr_hold |=> $stable(ctrl_q));

    p_live_load_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.wr_hold) |-> live == $past(stage));

    p_stage_capture_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.wr_hold) |-> stage == $past(live));
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .ptr_q(ptr_q), .flags_q(flags_q), .ctrl_q(ctrl_q),
    .live(live), .snap(snap), .stage(stage)
);

// File: tb/rtc_regbank_bench.sv
module rtc_regbank_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       start = 1'b0;
    logic [3:0] start_addr = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    int         n_checks = 0;
    int         n_fails  = 0;

    always #2 clk = ~clk;

    rtc_regbank u_rtc_regbank (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .start(start),
        .start_addr(start_addr), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr_at(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        start = 1'b1; start_addr = a; wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        start = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic wr_next(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd_at(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        start = 1'b1; start_addr = a; rd_stb = 1'b1;
        @(negedge clk);
        start = 1'b0; rd_stb = 1'b0; d = rd_data;
    endtask

    task automatic rd_next(output logic [7:0] d);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 rd_data", rd_data, 8'h00);
        rd_at(0, d); check("R1 flags", d, 8'h00);
        rd_next(d);  check("R1 sec", d, 8'h00);
        rd_at(4, d); check("R1 dow", d, 8'h01);
        rd_next(d);  check("R1 date", d, 8'h01);
        rd_next(d);  check("R1 month", d, 8'h01);
        rd_next(d);  check("R1 year", d, 8'h00);
        rd_at(12, d); check("R1 ctrl12", d, 8'h00);
    endtask

    task automatic t_locked;
        logic [7:0] d;
        wr_at(1, 8'h30);
        wr_at(9, 8'hAA);
        rd_at(1, d); check("R6 sec dropped", d, 8'h00);
        rd_at(9, d); check("R6 ctrl dropped", d, 8'h00);
    endtask

    task automatic t_set_time;
        logic [7:0] d;
        wr_at(0, 8'h02);
        wr_at(1, 8'h58);
        wr_next(8'h59); wr_next(8'h23); wr_next(8'h07);
        wr_next(8'h31); wr_next(8'h12); wr_next(8'h99);
        rd_at(1, d); check("R7 live untouched", d, 8'h00);
        ticks(1);
        rd_at(1, d); check("R7 live ticks under W", d, 8'h01);
        wr_at(0, 8'h00);
        rd_at(1, d); check("R7 load sec", d, 8'h58);
        rd_at(7, d); check("R7 load year", d, 8'h99);
    endtask

    task automatic t_rollover;
        logic [7:0] d;
        logic [7:0] exp [7] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        ticks(1);
        rd_at(1, d); check("R4 sec 59", d, 8'h59);
        ticks(1);
        rd_at(1, d); check("R4 roll field 0", d, exp[0]);
        for (int i = 1; i < 7; i++) begin
            rd_next(d); check($sformatf("R4 roll field %0d", i), d, exp[i]);
        end
    endtask

    task automatic t_snapshot;
        logic [7:0] d;
        wr_at(0, 8'h01);
        ticks(3);
        rd_at(1, d); check("R5 frozen sec", d, 8'h00);
        rd_at(0, d); check("R8 R bit reads back", d, 8'h01);
        wr_at(0, 8'h00);
        rd_at(1, d); check("R5 live after release", d, 8'h03);
    endtask

    task automatic t_carry;
        logic [7:0] d;
        wr_at(0, 8'h02);
        wr_at(1, 8'h09);
        wr_at(0, 8'h00);
        ticks(1);
        rd_at(1, d); check("R4 BCD digit carry", d, 8'h10);
        rd_next(d);  check("R4 min unchanged", d, 8'h00);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        wr_at(0, 8'h02);
        wr_at(14, 8'h11);
        wr_next(8'h22);
        wr_next(8'h02);
        wr_next(8'h45);
        rd_at(15, d); check("R9 ctrl15", d, 8'h22);
        rd_next(d);   check("R3 wrap to flags", d, 8'h02);
        rd_next(d);   check("R7 sec still live", d, 8'h10);
        rd_at(14, d); check("R9 ctrl14", d, 8'h11);
        wr_at(0, 8'h00);
        rd_at(1, d); check("R7 staged sec loaded", d, 8'h45);
        rd_at(2, d); check("R2 single read min", d, 8'h00);
    endtask

    task automatic t_flags;
        logic [7:0] d;
        wr_at(0, 8'hFC);
        rd_at(0, d); check("R8 reserved bits zero", d, 8'h00);
        wr_at(0, 8'hFF);
        rd_at(0, d); check("R8 both flags", d, 8'h03);
        wr_at(0, 8'h00);
        rd_at(0, d); check("R8 flags cleared", d, 8'h00);
        rd_at(14, d); check("R9 ctrl kept", d, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_locked;
        t_set_time;
        t_rollover;
        t_snapshot;
        t_carry;
        t_wrap;
        t_flags;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule